// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical address by comparing it, in a single cycle, against a small set of block translation entries. There are two independent entry arrays, one searched for instruction fetches and one for data accesses. Each entry describes a naturally aligned region: a base (effective page index), a mask that selects which address bits must match, a physical block number that replaces those bits, two privilege-valid bits and a 2-bit protection code.

A request carries the address, the instruction/data select, the privilege level and a write flag. One clock later the block returns a one-cycle response strobe with a hit flag, the physical address and the read/write/execute rights of the winning entry. A miss hands the access on to a page-table walker elsewhere. An entry that matches the address but forbids the access is skipped, and the search goes on to the entries after it, so a later entry covering the same region can still serve the access. Entries are loaded one at a time through a write port.

Top module: `bat_xlate`

## Requirements
- R1: After reset every entry in both arrays is cleared. No entry takes part in a lookup until it has been written, and all response outputs are 0.
- R2: `req_data`=1 searches the data array and `req_data`=0 searches the instruction array. `cfg_dside` picks the same way which array a write lands in.
- R3: An entry takes part only if `req_user`=1 and its user-valid bit is set, or `req_user`=0 and its supervisor-valid bit is set.
- R4: An entry matches when `(req_ea & mask) == epi`.
- R5: On a hit, `rsp_pa = pbn | (req_ea & ~mask)` of the winning entry.
- R6: The protection code decides the rights: 0 gives no access, 1 gives read-only, and 2 or 3 gives read/write. On a hit, `rsp_rd`=1, `rsp_ex`=1 and `rsp_wr`=1 exactly when the code is 2 or 3.
- R7: A matching entry with code 0, or with code 1 on a write, is passed over without a fault, and the search continues with higher-indexed entries.
- R8: Of the entries that match and allow the access, the one with the lowest index wins.
- R9: When no entry qualifies, the response has `rsp_hit`=0, `rsp_pa`=0 and `rsp_rd`=`rsp_wr`=`rsp_ex`=0.
- R10: `rsp_valid` is high for exactly the cycle after each cycle with `req_valid`=1. In cycles without a response, the other response outputs keep their last values.
- R11: A write and a lookup in the same cycle do not interfere. The lookup sees the entry contents from before the write, and the new contents serve lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_dside | input | 1 | Target array: 1 data, 0 instruction |
| cfg_idx | input | 3 | Entry index to write |
| cfg_epi | input | 32 | Effective page index (match value) |
| cfg_mask | input | 32 | Match mask |
| cfg_pbn | input | 32 | Physical block number |
| cfg_uv | input | 1 | Valid in user mode |
| cfg_sv | input | 1 | Valid in supervisor mode |
| cfg_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | 1 data access, 0 instruction fetch |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |

## Verification
An entry write and a lookup can occur in the same cycle, and that lookup may target the very entry being rewritten. The bench drives both on the same edge, with new contents that would change the outcome (a miss turning into a hit, or a different physical block). It expects the response to reflect the old contents and the following lookup to reflect the new ones. A behavioural reference model applies writes only after it has evaluated the lookup, and it is compared with the outputs on every clock, including during randomized traffic where writes and lookups collide freely.

// File: rtl/bat_xlate.sv
module bat_xlate #(
  parameter int AW   = 32,
  parameter int NENT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_dside,
  input  logic [$clog2(NENT)-1:0]  cfg_idx,
  input  logic [AW-1:0]            cfg_epi,
  input  logic [AW-1:0]            cfg_mask,
  input  logic [AW-1:0]            cfg_pbn,
  input  logic                     cfg_uv,
  input  logic                     cfg_sv,
  input  logic [1:0]               cfg_prot,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_ea,
  input  logic                     req_data,
  input  logic                     req_user,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [AW-1:0]            rsp_pa,
  output logic                     rsp_rd,
  output logic                     rsp_wr,
  output logic                     rsp_ex
);
  localparam int IW = $clog2(NENT);

  logic [AW-1:0] epi_q  [2][NENT];
  logic [AW-1:0] mask_q [2][NENT];
  logic [AW-1:0] pbn_q  [2][NENT];
  logic          uv_q   [2][NENT];
  logic          sv_q   [2][NENT];
  logic [1:0]    prot_q [2][NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < NENT; i++) begin
          epi_q[s][i]  <= '0;
          mask_q[s][i] <= '0;
          pbn_q[s][i]  <= '0;
          uv_q[s][i]   <= 1'b0;
          sv_q[s][i]   <= 1'b0;
          prot_q[s][i] <= 2'd0;
        end
    end else if (cfg_we) begin
      epi_q[cfg_dside][cfg_idx]  <= cfg_epi;
      mask_q[cfg_dside][cfg_idx] <= cfg_mask;
      pbn_q[cfg_dside][cfg_idx]  <= cfg_pbn;
      uv_q[cfg_dside][cfg_idx]   <= cfg_uv;
      sv_q[cfg_dside][cfg_idx]   <= cfg_sv;
      prot_q[cfg_dside][cfg_idx] <= cfg_prot;
    end
  end

  logic [NENT-1:0] cand;

  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    logic on, match, allow;
    assign on    = req_user ? uv_q[req_data][i] : sv_q[req_data][i];
    assign match = (req_ea & mask_q[req_data][i]) == epi_q[req_data][i];
    assign allow = (prot_q[req_data][i] != 2'd0) &&
                   !(req_write && prot_q[req_data][i] == 2'd1);
    assign cand[i] = on && match && allow;
  end

  logic          found;
  logic [IW-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (cand[i]) begin
        found = 1'b1;
        win   = IW'(i);
      end
  end

  logic [AW-1:0] pa_nx;
  assign pa_nx = pbn_q[req_data][win] | (req_ea & ~mask_q[req_data][win]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit <= found;
        rsp_pa  <= found ? pa_nx : '0;
        rsp_rd  <= found;
        rsp_wr  <= found && prot_q[req_data][win][1];
        rsp_ex  <= found;
      end
    end
  end
endmodule

module bat_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [AW-1:0] rsp_pa,
  input logic          rsp_rd,
  input logic          rsp_wr,
  input logic          rsp_ex
);
  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_hit) && $stable(rsp_pa) && $stable(rsp_wr));
  // R6
  hit_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_rd && rsp_ex);
  // R9
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_pa == '0 && !rsp_rd && !rsp_wr && !rsp_ex);
  // R7
  write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && $past(req_write) |-> rsp_wr);
endmodule

bind bat_xlate bat_xlate_chk #(.AW(AW)) chk (.*);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_dside = 0, cfg_uv = 0, cfg_sv = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_epi = 0, cfg_mask = 0, cfg_pbn = 0;
  logic [1:0] cfg_prot = 0;
  logic req_valid = 0, req_data = 0, req_user = 0, req_write = 0;
  logic [31:0] req_ea = 0;
  logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_pa;

  int checks = 0, errors = 0;
  bit live = 0;

  always #10 clk = ~clk;

  bat_xlate uut (.*);

  logic [31:0] m_epi [2][8], m_mask [2][8], m_pbn [2][8];
  bit m_uv [2][8], m_sv [2][8];
  int m_prot [2][8];
  bit e_valid, e_hit, e_rd, e_wr, e_ex;
  logic [31:0] e_pa;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_epi[s, i]) begin
        m_epi[s][i] = 0; m_mask[s][i] = 0; m_pbn[s][i] = 0;
        m_uv[s][i] = 0; m_sv[s][i] = 0; m_prot[s][i] = 0;
      end
      {e_valid, e_hit, e_rd, e_wr, e_ex} = 0; e_pa = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int s; int hit_at;
        s = req_data; hit_at = -1;
        for (int i = 0; i < 8 && hit_at < 0; i++) begin
          bit ok;
          ok = req_user ? m_uv[s][i] : m_sv[s][i];
          if (ok && (req_ea & m_mask[s][i]) == m_epi[s][i]) begin
            if (m_prot[s][i] == 0) ok = 0;
            else if (req_write && m_prot[s][i] == 1) ok = 0;
            if (ok) hit_at = i;
          end
        end
        if (hit_at < 0) begin
          {e_hit, e_rd, e_wr, e_ex} = 0; e_pa = 0;
        end else begin
          e_hit = 1; e_rd = 1; e_ex = 1;
          e_wr = m_prot[s][hit_at] >= 2;
          e_pa = m_pbn[s][hit_at] | (req_ea & ~m_mask[s][hit_at]);
        end
      end
      if (cfg_we) begin
        m_epi[cfg_dside][cfg_idx] = cfg_epi; m_mask[cfg_dside][cfg_idx] = cfg_mask;
        m_pbn[cfg_dside][cfg_idx] = cfg_pbn; m_uv[cfg_dside][cfg_idx] = cfg_uv;
        m_sv[cfg_dside][cfg_idx] = cfg_sv; m_prot[cfg_dside][cfg_idx] = cfg_prot;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R10 rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk("R8 rsp_hit", 32'(rsp_hit), 32'(e_hit));
    chk("R5 rsp_pa", rsp_pa, e_pa);
    chk("R6 rsp_rd", 32'(rsp_rd), 32'(e_rd));
    chk("R6 rsp_wr", 32'(rsp_wr), 32'(e_wr));
    chk("R6 rsp_ex", 32'(rsp_ex), 32'(e_ex));
  end

  task automatic set_cfg(bit d, int idx, logic [31:0] epi, logic [31:0] msk,
                         logic [31:0] pbn, bit uv, bit sv, int prot);
    cfg_we = 1; cfg_dside = d; cfg_idx = 3'(idx); cfg_epi = epi; cfg_mask = msk;
    cfg_pbn = pbn; cfg_uv = uv; cfg_sv = sv; cfg_prot = 2'(prot);
  endtask

  task automatic set_req(bit d, bit u, bit w, logic [31:0] ea);
    req_valid = 1; req_data = d; req_user = u; req_write = w; req_ea = ea;
  endtask

  task automatic step();
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic lookup(bit d, bit u, bit w, logic [31:0] ea, string tag,
                        bit hit, logic [31:0] pa, bit wr);
    set_req(d, u, w, ea); step();
    chk({tag, " hit"}, 32'(rsp_hit), 32'(hit));
    chk({tag, " pa"}, rsp_pa, pa);
    chk({tag, " wr"}, 32'(rsp_wr), 32'(wr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: clean outputs after reset
    chk("R1 rsp after reset", {rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex}, 0);
    live = 1;
    // R1, R9: empty table misses in every mode
    lookup(0, 0, 0, 32'h0000_0000, "R1 empty i", 0, 0, 0);
    lookup(1, 1, 1, 32'h1234_5678, "R9 empty d", 0, 0, 0);
    set_cfg(0, 2, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 0, 1, 2); step();
    set_cfg(1, 2, 32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 1, 1, 1); step();
    // R4, R5: supervisor instruction fetch
    lookup(0, 0, 0, 32'h1234_5678, "R5 i sup", 1, 32'h8234_5678, 1);
    // R3: user lacks valid bit on instruction entry
    lookup(0, 1, 0, 32'h1234_5678, "R3 i user", 0, 0, 0);
    // R2: data array selected, read-only entry
    lookup(1, 1, 0, 32'h1234_5678, "R2 d read", 1, 32'h4234_5678, 0);
    // R4: address outside region
    lookup(1, 1, 0, 32'h2234_5678, "R4 outside", 0, 0, 0);
    // R7: write to read-only entry falls through to a miss
    lookup(1, 1, 1, 32'h1234_5678, "R7 ro write", 0, 0, 0);
    set_cfg(1, 5, 32'h1000_0000, 32'hF000_0000, 32'h6000_0000, 1, 1, 3); step();
    set_cfg(1, 1, 32'h1000_0000, 32'hF000_0000, 32'h7000_0000, 1, 1, 0); step();
    // R7: write skips entry 1 (code 0) and entry 2 (code 1), lands on 5
    lookup(1, 1, 1, 32'h1234_5678, "R7 fallthrough", 1, 32'h6234_5678, 1);
    // R8: read takes entry 2 ahead of 5
    lookup(1, 0, 0, 32'h1234_5678, "R8 lowest", 1, 32'h4234_5678, 0);
    set_cfg(1, 0, 32'h1234_0000, 32'hFFFE_0000, 32'h0ABC_0000, 1, 1, 3); step();
    lookup(1, 1, 0, 32'h1235_5678, "R8 small blk", 1, 32'h0ABD_5678, 1);
    // R11: same-cycle write of entry 0 to a new block, lookup sees old one
    set_cfg(1, 0, 32'h1234_0000, 32'hFFFE_0000, 32'h0DEF_0000, 1, 1, 3);
    lookup(1, 1, 0, 32'h1235_5678, "R11 old", 1, 32'h0ABD_5678, 1);
    lookup(1, 1, 0, 32'h1235_5678, "R11 new", 1, 32'h0DEF_5678, 1);
    // R11: same-cycle enable of a miss-only entry
    set_cfg(0, 7, 32'h3000_0000, 32'hF000_0000, 32'h9000_0000, 1, 1, 2);
    lookup(0, 1, 0, 32'h3000_0010, "R11 miss first", 0, 0, 0);
    lookup(0, 1, 0, 32'h3000_0010, "R11 then hit", 1, 32'h9000_0010, 1);
    // R10: idle cycles hold outputs
    repeat (3) begin
      step();
      chk("R10 hold pa", rsp_pa, 32'h9000_0010);
    end
    // mixed traffic, model compares every clock
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] bases [4];
      bases = '{32'h1000_0000, 32'h1234_0000, 32'h3000_0000, 32'hA000_0000};
      if ($urandom_range(3) == 0) begin
        int b; b = $urandom_range(3);
        set_cfg($urandom_range(1), $urandom_range(7), bases[b],
                (b == 1) ? 32'hFFFE_0000 : 32'hF000_0000,
                $urandom & 32'hFFFE_0000, $urandom_range(1), $urandom_range(1),
                $urandom_range(3));
      end
      if ($urandom_range(3) != 0)
        set_req($urandom_range(1), $urandom_range(1), $urandom_range(1),
                bases[$urandom_range(3)] | ($urandom & 32'h0001_FFFF));
      step();
    end
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule